// File: doc/BRIEF.md
# Low-Power Link Speed Selector

This control block sits next to an Ethernet PHY auto-negotiation engine and decides which speeds the engine advertises on each attempt. When the power-saving link mode is in force, the first attempt offers only 10 Mb/s, whatever the configured advertisement is. Each failed attempt widens the offered set, so the link comes up at the slowest speed both ends can use. When the mode is not in force, the configured advertisement passes straight through for a single attempt.

The mode is decided once, at each negotiation start strobe. The decision uses four inputs:
- a register enable bit set by the MAC side;
- a non-volatile enable bit that applies in all non-active power states;
- a battery-saver override that wins in the fully active state;
- the power-state input.

Changes to these inputs between negotiations do nothing until the next start. The engine reports each attempt with a done strobe and a pass flag. The block answers with an attempt strobe, a new mask, or a resolved-speed code together with a link-valid flag.

Top module: `lpls_top`

## Requirements
- R1: If the mode is in force when `an_start` is sampled high, then on the next cycle `adv_mask` is 3'b001 and `try_go` is high for that one cycle. The mask bits are ordered {1000, 100, 10}.
- R2: If the 10 Mb/s-only attempt fails (`an_done` high and `an_pass` low), then on the next cycle `try_go` pulses and `adv_mask` offers every speed from 10 Mb/s up to the lowest speed in `partner_abil`. The result is 3'b011 when the partner's lowest speed is 10 or 100 Mb/s, or when `partner_abil` is empty, and 3'b111 when the partner offers only 1000 Mb/s. For example, a partner offering only 1000 and 100 Mb/s gets 3'b011 and links at 100 Mb/s.
- R3: A failed 3'b011 attempt is followed by a 3'b111 attempt with a `try_go` pulse. A failed 3'b111 attempt ends the sequence: `link_valid` stays low and no further `try_go` is issued.
- R4: A passing attempt raises `link_valid` on the next cycle. `link_speed` is then the highest speed present in both `adv_mask` and `partner_abil`, or the highest advertised speed if the two share none. The codes are 2'b00 for 10 Mb/s, 2'b01 for 100 Mb/s and 2'b10 for 1000 Mb/s.
- R5: The mode is in force under these conditions:
  - with `pwr_active` high, when `cfg_lp_en` is high and `batt_saver_en` is low;
  - with `pwr_active` low, when `cfg_lp_en` or `nv_lp_en` is high.
- R6: If the mode is not in force at a start, the next cycle shows `adv_mask` equal to `cfg_adv` with a `try_go` pulse. A failed attempt then ends the sequence with no fallback.
- R7: Changes to `cfg_lp_en`, `nv_lp_en`, `pwr_active`, `batt_saver_en` or `cfg_adv` without a start cause no `try_go` and leave `adv_mask` and `link_valid` unchanged.
- R8: An `an_start` during an ongoing sequence restarts it. `an_start` takes priority over an `an_done` in the same cycle.
- R9: After reset, `adv_mask` is 0, `link_speed` is 0, and `link_valid` and `try_go` are low.
- R10: An `an_done` that arrives while no attempt is pending (idle, linked or failed) changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lp_en | input | 1 | Register enable bit for the power-saving link mode |
| nv_lp_en | input | 1 | Non-volatile enable for non-active power states |
| pwr_active | input | 1 | 1 = fully active system state |
| batt_saver_en | input | 1 | Battery-saver speed override |
| cfg_adv | input | 3 | Configured advertisement {1000,100,10} |
| an_start | input | 1 | Negotiation start strobe |
| an_done | input | 1 | Attempt finished strobe |
| an_pass | input | 1 | Attempt outcome with `an_done` (1 = link up) |
| partner_abil | input | 3 | Partner speed abilities {1000,100,10} |
| adv_mask | output | 3 | Speeds to advertise {1000,100,10} |
| try_go | output | 1 | One-cycle strobe: begin an attempt with `adv_mask` |
| link_speed | output | 2 | Resolved speed code |
| link_valid | output | 1 | High only while linked |

## Verification
The assertions check on every cycle that a start in the power-saving mode leads to a 10 Mb/s-only offer and that a start outside the mode copies the configured mask. They also check that attempt strobes follow only a start or a failed attempt, that the mask holds while no strobe arrives, and that a passing attempt brings the link up. Only the bench scenarios can show the following: the full widening order for every partner ability set, the resolved speed code, the outcome of each combination of the enable inputs, and restart priority. They likewise show that setting changes stay latent until the next start.

// File: rtl/lpls_pkg.sv
package lpls_pkg;
    localparam int NSPD = 3;
    localparam int SPDW = $clog2(NSPD);

    typedef logic [NSPD-1:0] spd_mask_t;

    localparam spd_mask_t MASK_LOW  = spd_mask_t'(1);
    localparam spd_mask_t MASK_PAIR = spd_mask_t'(3);
    localparam spd_mask_t MASK_ALL  = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRY_10,
        ST_TRY_100,
        ST_TRY_1000,
        ST_LINKED,
        ST_FAIL,
        ST_DIRECT
    } sel_state_t;

    typedef struct packed {
        sel_state_t      state;
        spd_mask_t       adv;
        logic [SPDW-1:0] spd;
        logic            lv;
        logic            go;
    } sel_regs_t;
endpackage

// File: rtl/lpls_policy.sv
module lpls_policy (
    input  logic pwr_active,
    input  logic cfg_lp_en,
    input  logic nv_lp_en,
    input  logic batt_saver_en,
    output logic lp_on
);
    logic on_active;
    logic on_sleep;

    always_comb begin
        // Active state: battery saver overrides the mode (R5)
        on_active = cfg_lp_en & ~batt_saver_en;
        // Non-active states: the stored bit also enables it
        on_sleep  = cfg_lp_en | nv_lp_en;
        lp_on     = pwr_active ? on_active : on_sleep;
    end
endmodule

// File: rtl/lpls_mask_math.sv
module lpls_mask_math #(
    parameter int N = 3,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  partner,
    input  logic [N-1:0]  adv,
    output logic [N-1:0]  widen,
    output logic [CW-1:0] win_code
);
    logic [N-1:0] common;
    int           low_idx;
    int           top_adv;
    int           top_com;
    int           limit;

    // lowest partner speed, at least the second tier
    always_comb begin
        low_idx = 1;
        for (int i = N - 1; i >= 0; i--) begin
            if (partner[i]) low_idx = i;
        end
        limit = (low_idx < 1) ? 1 : low_idx;
    end

    for (genvar g = 0; g < N; g++) begin : g_widen
        assign widen[g] = (g <= limit);
    end

    // highest shared speed, else highest advertised
    always_comb begin
        common  = adv & partner;
        top_adv = 0;
        top_com = -1;
        for (int i = 0; i < N; i++) begin
            if (adv[i])    top_adv = i;
            if (common[i]) top_com = i;
        end
        win_code = (top_com >= 0) ? CW'(top_com) : CW'(top_adv);
    end
endmodule

// File: rtl/lpls_top.sv
module lpls_top
    import lpls_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_lp_en,
    input  logic            nv_lp_en,
    input  logic            pwr_active,
    input  logic            batt_saver_en,
    input  logic [NSPD-1:0] cfg_adv,
    input  logic            an_start,
    input  logic            an_done,
    input  logic            an_pass,
    input  logic [NSPD-1:0] partner_abil,
    output logic [NSPD-1:0] adv_mask,
    output logic            try_go,
    output logic [SPDW-1:0] link_speed,
    output logic            link_valid
);
    sel_regs_t       r_d, r_q;
    logic            lp_on;
    spd_mask_t       widen_mask;
    logic [SPDW-1:0] win_code;
    logic            busy;

    lpls_policy u_policy (
        .pwr_active    (pwr_active),
        .cfg_lp_en     (cfg_lp_en),
        .nv_lp_en      (nv_lp_en),
        .batt_saver_en (batt_saver_en),
        .lp_on         (lp_on)
    );

    lpls_mask_math #(.N(NSPD)) u_math (
        .partner  (partner_abil),
        .adv      (r_q.adv),
        .widen    (widen_mask),
        .win_code (win_code)
    );

    always_comb begin
        busy = (r_q.state == ST_TRY_10)   || (r_q.state == ST_TRY_100) ||
               (r_q.state == ST_TRY_1000) || (r_q.state == ST_DIRECT);
    end

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        if (an_start) begin
            r_d.lv  = 1'b0;
            r_d.spd = '0;
            r_d.go  = 1'b1;
            if (lp_on) begin
                r_d.state = ST_TRY_10;
                r_d.adv   = MASK_LOW;
            end else begin
                r_d.state = ST_DIRECT;
                r_d.adv   = cfg_adv;
            end
        end else if (an_done && busy) begin
            if (an_pass) begin
                r_d.state = ST_LINKED;
                r_d.lv    = 1'b1;
                r_d.spd   = win_code;
            end else begin
                unique case (r_q.state)
                    ST_TRY_10: begin
                        r_d.adv   = widen_mask;
                        r_d.state = (widen_mask == MASK_PAIR) ? ST_TRY_100 : ST_TRY_1000;
                        r_d.go    = 1'b1;
                    end
                    ST_TRY_100: begin
                        r_d.adv   = MASK_ALL;
                        r_d.state = ST_TRY_1000;
                        r_d.go    = 1'b1;
                    end
                    default: r_d.state = ST_FAIL;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.adv   <= '0;
            r_q.spd   <= '0;
            r_q.lv    <= 1'b0;
            r_q.go    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign adv_mask   = r_q.adv;
    assign try_go     = r_q.go;
    assign link_speed = r_q.spd;
    assign link_valid = r_q.lv;

    a_r1_first_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (an_start && lp_on) |=> (adv_mask == MASK_LOW) && try_go);

    a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (an_start && !lp_on) |=> (adv_mask == $past(cfg_adv)) && try_go);

    a_r2_widen_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (an_done && !an_pass && !an_start && r_q.state == ST_TRY_10)
        |=> adv_mask[0] && adv_mask[1] && try_go);

    a_r7_go_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(try_go) |-> $past(an_start) || $past(an_done && !an_pass));

    a_r7_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!an_start && !an_done) |=> $stable(adv_mask) && !try_go);

    a_r4_pass_links: assert property (@(posedge clk) disable iff (!rst_n)
        (an_done && an_pass && !an_start && busy) |=> link_valid);
endmodule

// File: tb/lpls_top_test.sv
module lpls_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_lp_en = 1'b0, nv_lp_en = 1'b0, pwr_active = 1'b0, batt_saver_en = 1'b0;
    logic [2:0] cfg_adv = 3'b110;
    logic       an_start = 1'b0, an_done = 1'b0, an_pass = 1'b0;
    logic [2:0] partner_abil = 3'b000;
    logic [2:0] adv_mask;
    logic       try_go;
    logic [1:0] link_speed;
    logic       link_valid;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       finished = 1'b0;

    lpls_top uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        an_start = 1'b1;
        @(negedge clk);
        an_start = 1'b0;
    endtask

    task automatic do_done(input logic pass);
        an_done = 1'b1;
        an_pass = pass;
        @(negedge clk);
        an_done = 1'b0;
        an_pass = 1'b0;
    endtask

    function automatic int hi_bit(input logic [2:0] m);
        int h = 0;
        for (int i = 0; i < 3; i++) if (m[i]) h = i;
        return h;
    endfunction

    function automatic logic [2:0] widen_of(input logic [2:0] p);
        if (p == 3'b100) return 3'b111;
        return 3'b011;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 mask", int'(adv_mask), 0);
        chk("R9 go", int'(try_go), 0);
        chk("R9 speed", int'(link_speed), 0);
        chk("R9 valid", int'(link_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: sweep partner sets and the attempt that passes
        cfg_lp_en = 1'b1;
        pwr_active = 1'b1;
        for (int p = 0; p < 8; p++) begin
            for (int pass_at = 0; pass_at < 4; pass_at++) begin
                logic [2:0] seq [3];
                int n_try;
                partner_abil = 3'(p);
                seq[0] = 3'b001;
                seq[1] = widen_of(3'(p));
                seq[2] = 3'b111;
                n_try = (seq[1] == 3'b011) ? 3 : 2;
                do_start();
                for (int k = 0; k < n_try; k++) begin
                    chk(k == 0 ? "R1 mask" : (k == 1 ? "R2 mask" : "R3 mask"),
                        int'(adv_mask), int'(seq[k]));
                    chk("R1 go", int'(try_go), 1);
                    if (k == pass_at) begin
                        logic [2:0] c;
                        c = seq[k] & 3'(p);
                        do_done(1'b1);
                        chk("R4 valid", int'(link_valid), 1);
                        chk("R4 speed", int'(link_speed),
                            (c != 0) ? hi_bit(c) : hi_bit(seq[k]));
                        break;
                    end
                    do_done(1'b0);
                end
                if (pass_at >= n_try) begin
                    chk("R3 fail valid", int'(link_valid), 0);
                    chk("R3 fail go", int'(try_go), 0);
                end
            end
        end

        // R2 example: partner {1000,100}, attempts fail until second passes
        partner_abil = 3'b110;
        do_start();
        do_done(1'b0);
        chk("R2 example mask", int'(adv_mask), 3);
        do_done(1'b1);
        chk("R2 example speed", int'(link_speed), 1);

        // R5 R6: every combination of the enable inputs
        for (int e = 0; e < 16; e++) begin
            logic exp_on;
            {pwr_active, cfg_lp_en, nv_lp_en, batt_saver_en} = 4'(e);
            exp_on = pwr_active ? (cfg_lp_en & ~batt_saver_en) : (cfg_lp_en | nv_lp_en);
            partner_abil = 3'b110;
            do_start();
            chk("R5 mode mask", int'(adv_mask), exp_on ? 1 : 6);
            if (!exp_on) begin
                do_done(1'b0);
                chk("R6 no fallback go", int'(try_go), 0);
                chk("R6 no fallback valid", int'(link_valid), 0);
                chk("R6 mask held", int'(adv_mask), 6);
            end
        end

        // R7: setting changes during an attempt are latent
        pwr_active = 1'b1; cfg_lp_en = 1'b1; batt_saver_en = 1'b0;
        do_start();
        cfg_lp_en = 1'b0;
        cfg_adv = 3'b101;
        batt_saver_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 mask", int'(adv_mask), 1);
        chk("R7 go", int'(try_go), 0);
        chk("R7 valid", int'(link_valid), 0);
        // new setting applies at the next start
        do_start();
        chk("R7 next start", int'(adv_mask), 5);

        // R8: restart wins over a simultaneous done
        cfg_lp_en = 1'b1; batt_saver_en = 1'b0; cfg_adv = 3'b110;
        partner_abil = 3'b111;
        do_start();
        do_done(1'b0);
        chk("R8 in 100 tier", int'(adv_mask), 3);
        an_start = 1'b1; an_done = 1'b1; an_pass = 1'b1;
        @(negedge clk);
        an_start = 1'b0; an_done = 1'b0; an_pass = 1'b0;
        chk("R8 restart mask", int'(adv_mask), 1);
        chk("R8 restart valid", int'(link_valid), 0);
        chk("R8 restart go", int'(try_go), 1);

        // R10: stray done while linked
        do_done(1'b1);
        chk("R10 linked", int'(link_valid), 1);
        do_done(1'b0);
        chk("R10 still linked", int'(link_valid), 1);
        chk("R10 no go", int'(try_go), 0);
        chk("R10 mask", int'(adv_mask), 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule